// File: doc/BRIEF.md
# Bridge Delayed-Read Ordering Controller

This controller decides, cycle by cycle, how a bridge between a host-side system bus and a PCI-like secondary bus answers the requests that reach it from both sides. Buffers, protocol signalling and address decoding live elsewhere. The controller sees the fill level of the two posted-write buffers, one per direction, and a one-request-per-cycle handshake from each master side. It answers every request in the same cycle, either accepting it or telling the master to retry (secondary side) or to rearbitrate (host side).

Secondary-bus reads are served as delayed reads. The first read is retried and its address latched. The controller then waits until the secondary-to-host writes that were queued at that moment have retired on the host bus. Writes posted later do not extend the wait. Once the drain is done it launches one host-side read, holds the returned data, and hands it over only to a later read with the same address. Host reads, non-postable host writes and internal configuration writes are held back by the ordering rules below.

Top module: `bdr_order_ctrl`

## Requirements
- R1: After reset the controller is idle. With no request present, no accept, retry, rearbitrate, launch or data-valid output is raised.
- R2: A secondary-bus write is accepted when the secondary posted-write count is below SEC_DEPTH. Otherwise it is retried.
- R3: In the idle phase, a secondary-bus read is retried, its address is latched and the request phase begins. Every secondary-bus read during the request phase is retried. In the completion phase, a read whose address differs from the latched one is retried.
- R4: On entering the request phase, the controller records the secondary posted-write count less any retirement in that same cycle. The host-side read is launched only in the first request-phase cycle in which that many retirements have been seen since the read was latched. Writes accepted later do not delay the launch.
- R5: The launch strobe lasts exactly one cycle and carries the latched address. The completion phase follows in the next cycle.
- R6: In the completion phase, the first read-return pulse stores its data. A read with the latched address arriving after that cycle is accepted, with the held data and a one-cycle data-valid flag, and the controller returns to idle. A matching read that arrives before the data is held is retried.
- R7: A postable host write (configuration flag low, postable flag high) is accepted when the host posted-write count is below HOST_DEPTH, whatever the secondary bus is doing.
- R8: A host read (configuration flag low) is accepted only when both posted-write counts are zero and no secondary request is present.
- R9: Any secondary request present in the same cycle makes a host read or a non-postable host write rearbitrate.
- R10: A host configuration write is accepted only when both posted-write counts are zero and the controller is idle. A host configuration read is always accepted.
- R11: Every valid request on either side gets exactly one of its two responses in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_wr_cnt | input | $clog2(SEC_DEPTH+1) | Entries in the secondary-to-host posted-write buffer |
| host_wr_cnt | input | $clog2(HOST_DEPTH+1) | Entries in the host-to-secondary posted-write buffer |
| sec_wr_retire | input | 1 | One secondary-side posted write completed on the host bus |
| sec_req_valid | input | 1 | Secondary-bus master request present |
| sec_req_write | input | 1 | 1 = write, 0 = read |
| sec_req_addr | input | ADDR_W | Secondary request address |
| sec_accept | output | 1 | Secondary request accepted (write taken or read data delivered) |
| sec_retry | output | 1 | Secondary request must retry |
| sec_rd_data | output | DATA_W | Delivered read data |
| sec_rd_data_valid | output | 1 | Read data delivered this cycle |
| host_req_valid | input | 1 | Host-bus master request present |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_postable | input | 1 | Write may be posted |
| host_req_cfg | input | 1 | Internal configuration access |
| host_accept | output | 1 | Host request accepted |
| host_rearb | output | 1 | Host request must rearbitrate |
| dn_rd_launch | output | 1 | Launch the delayed read on the host bus |
| dn_rd_addr | output | ADDR_W | Address of the launched read |
| dn_rd_ret_valid | input | 1 | Launched read data returned |
| dn_rd_ret_data | input | DATA_W | Returned read data |

## Verification
The bench builds the block with SEC_DEPTH and HOST_DEPTH set to 4. This lets it drive the full and one-below-full buffer counts on both sides, and a drain of several pending writes, within a few cycles. ADDR_W and DATA_W are reduced to 16, which keeps matching and mismatching addresses easy to pick. A behavioural model of the phases and the drain count predicts every response on every cycle. This covers a read with nothing pending, a drain overtaken by newer writes, early and mismatched retries, and configuration writes attempted during a delayed read.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
   typedef enum logic [1:0] {
      DR_IDLE = 2'd0,
      DR_REQ  = 2'd1,
      DR_CPL  = 2'd2
   } dr_phase_e;
endpackage

// File: rtl/bdr_drain_track.sv
module bdr_drain_track #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          active,
   input  logic          retire,
   input  logic [CW-1:0] cnt,
   output logic          drained
);
   logic [CW-1:0] snap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_q <= '0;
      end else if (start) begin
         snap_q <= cnt - CW'(retire);
      end else if (active && retire && snap_q != '0) begin
         snap_q <= snap_q - CW'(1);
      end
   end

   assign drained = (snap_q == '0);

   p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !start && !retire) |=> $stable(snap_q));
endmodule

// File: rtl/bdr_read_fsm.sv
module bdr_read_fsm
   import bdr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_rd,
   input  logic [ADDR_W-1:0] sec_addr,
   input  logic              drained,
   input  logic              ret_valid,
   input  logic [DATA_W-1:0] ret_data,
   output dr_phase_e         phase,
   output logic              start,
   output logic              launch,
   output logic [ADDR_W-1:0] launch_addr,
   output logic              deliver,
   output logic [DATA_W-1:0] held_data
);
   dr_phase_e         phase_q, phase_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              dvalid_q;

   assign start   = (phase_q == DR_IDLE) && sec_rd;
   assign launch  = (phase_q == DR_REQ) && drained;
   assign deliver = (phase_q == DR_CPL) && dvalid_q && sec_rd && (sec_addr == addr_q);

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         DR_IDLE: if (start)   phase_d = DR_REQ;
         DR_REQ:  if (launch)  phase_d = DR_CPL;
         DR_CPL:  if (deliver) phase_d = DR_IDLE;
         default:              phase_d = DR_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= DR_IDLE;
         addr_q   <= '0;
         data_q   <= '0;
         dvalid_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (start) addr_q <= sec_addr;
         if (launch || deliver) begin
            dvalid_q <= 1'b0;
         end else if (phase_q == DR_CPL && ret_valid && !dvalid_q) begin
            dvalid_q <= 1'b1;
            data_q   <= ret_data;
         end
      end
   end

   assign phase       = phase_q;
   assign launch_addr = addr_q;
   assign held_data   = data_q;

   p_enter_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (phase_q == DR_REQ));
   p_launch_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (!launch && phase_q == DR_CPL));
   p_deliver_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      deliver |=> (phase_q == DR_IDLE));
   p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != DR_IDLE) |=> $stable(addr_q));
endmodule

// File: rtl/bdr_admit.sv
module bdr_admit
   import bdr_pkg::*;
#(
   parameter int SEC_DEPTH  = 8,
   parameter int HOST_DEPTH = 8,
   parameter int SEC_CW     = 4,
   parameter int HOST_CW    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEC_CW-1:0]  sec_wr_cnt,
   input  logic [HOST_CW-1:0] host_wr_cnt,
   input  dr_phase_e          phase,
   input  logic               deliver,
   input  logic               sec_req_valid,
   input  logic               sec_req_write,
   input  logic               host_req_valid,
   input  logic               host_req_write,
   input  logic               host_req_postable,
   input  logic               host_req_cfg,
   output logic               sec_accept,
   output logic               sec_retry,
   output logic               host_accept,
   output logic               host_rearb
);
   localparam logic [SEC_CW-1:0]  SEC_FULL  = SEC_CW'(SEC_DEPTH);
   localparam logic [HOST_CW-1:0] HOST_FULL = HOST_CW'(HOST_DEPTH);

   logic sec_room, host_room, both_empty, sec_ok, host_ok;

   assign sec_room   = sec_wr_cnt < SEC_FULL;
   assign host_room  = host_wr_cnt < HOST_FULL;
   assign both_empty = (sec_wr_cnt == '0) && (host_wr_cnt == '0);

   always_comb begin
      sec_ok = sec_req_write ? sec_room : deliver;
      if (host_req_cfg)
         host_ok = host_req_write ? (both_empty && phase == DR_IDLE) : 1'b1;
      else if (host_req_write && host_req_postable)
         host_ok = host_room;
      else if (host_req_write)
         host_ok = !sec_req_valid;
      else
         host_ok = !sec_req_valid && both_empty;
   end

   assign sec_accept  = sec_req_valid && sec_ok;
   assign sec_retry   = sec_req_valid && !sec_ok;
   assign host_accept = host_req_valid && host_ok;
   assign host_rearb  = host_req_valid && !host_ok;

   p_one_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_req_valid |-> $countones({sec_accept, sec_retry}) == 1) and
      (host_req_valid |-> $countones({host_accept, host_rearb}) == 1));
   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_accept && sec_req_write) |-> (sec_wr_cnt < SEC_FULL));
   p_host_rd_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_accept && !host_req_write && !host_req_cfg) |-> (both_empty && !sec_req_valid));
   p_cfg_wr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_accept && host_req_write && host_req_cfg) |-> (both_empty && phase == DR_IDLE));
endmodule

// File: rtl/bdr_order_ctrl.sv
module bdr_order_ctrl
   import bdr_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int SEC_DEPTH  = 8,
   parameter int HOST_DEPTH = 8,
   localparam int SEC_CW    = $clog2(SEC_DEPTH + 1),
   localparam int HOST_CW   = $clog2(HOST_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEC_CW-1:0]  sec_wr_cnt,
   input  logic [HOST_CW-1:0] host_wr_cnt,
   input  logic               sec_wr_retire,
   input  logic               sec_req_valid,
   input  logic               sec_req_write,
   input  logic [ADDR_W-1:0]  sec_req_addr,
   output logic               sec_accept,
   output logic               sec_retry,
   output logic [DATA_W-1:0]  sec_rd_data,
   output logic               sec_rd_data_valid,
   input  logic               host_req_valid,
   input  logic               host_req_write,
   input  logic               host_req_postable,
   input  logic               host_req_cfg,
   output logic               host_accept,
   output logic               host_rearb,
   output logic               dn_rd_launch,
   output logic [ADDR_W-1:0]  dn_rd_addr,
   input  logic               dn_rd_ret_valid,
   input  logic [DATA_W-1:0]  dn_rd_ret_data
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("bdr_order_ctrl: ADDR_W and DATA_W must be positive");
      end
      if (SEC_DEPTH < 1 || HOST_DEPTH < 1) begin : g_bad_depth
         $error("bdr_order_ctrl: buffer depths must be at least 1");
      end
   endgenerate

   dr_phase_e phase;
   logic      sec_rd, start, drained, launch, deliver;

   assign sec_rd = sec_req_valid && !sec_req_write;

   bdr_drain_track #(.CW(SEC_CW)) u_drain (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .active  (phase == DR_REQ),
      .retire  (sec_wr_retire),
      .cnt     (sec_wr_cnt),
      .drained (drained)
   );

   bdr_read_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sec_rd      (sec_rd),
      .sec_addr    (sec_req_addr),
      .drained     (drained),
      .ret_valid   (dn_rd_ret_valid),
      .ret_data    (dn_rd_ret_data),
      .phase       (phase),
      .start       (start),
      .launch      (launch),
      .launch_addr (dn_rd_addr),
      .deliver     (deliver),
      .held_data   (sec_rd_data)
   );

   bdr_admit #(
      .SEC_DEPTH (SEC_DEPTH),
      .HOST_DEPTH(HOST_DEPTH),
      .SEC_CW    (SEC_CW),
      .HOST_CW   (HOST_CW)
   ) u_admit (
      .clk               (clk),
      .rst_n             (rst_n),
      .sec_wr_cnt        (sec_wr_cnt),
      .host_wr_cnt       (host_wr_cnt),
      .phase             (phase),
      .deliver           (deliver),
      .sec_req_valid     (sec_req_valid),
      .sec_req_write     (sec_req_write),
      .host_req_valid    (host_req_valid),
      .host_req_write    (host_req_write),
      .host_req_postable (host_req_postable),
      .host_req_cfg      (host_req_cfg),
      .sec_accept        (sec_accept),
      .sec_retry         (sec_retry),
      .host_accept       (host_accept),
      .host_rearb        (host_rearb)
   );

   assign dn_rd_launch      = launch;
   assign sec_rd_data_valid = deliver;

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_req_valid && !host_req_valid) |-> !(sec_accept || sec_retry || host_accept || host_rearb || sec_rd_data_valid));
endmodule

// File: tb/bdr_order_ctrl_test.sv
module bdr_order_ctrl_test;
   localparam int PER = 10;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int SD = 4;
   localparam int HD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] sec_wr_cnt = '0;
   logic [2:0] host_wr_cnt = '0;
   logic sec_wr_retire = 1'b0;
   logic sec_req_valid = 1'b0, sec_req_write = 1'b0;
   logic [AW-1:0] sec_req_addr = '0;
   logic host_req_valid = 1'b0, host_req_write = 1'b0, host_req_postable = 1'b0, host_req_cfg = 1'b0;
   logic dn_rd_ret_valid = 1'b0;
   logic [DW-1:0] dn_rd_ret_data = '0;
   logic sec_accept, sec_retry, sec_rd_data_valid, host_accept, host_rearb, dn_rd_launch;
   logic [DW-1:0] sec_rd_data;
   logic [AW-1:0] dn_rd_addr;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   // model state
   int m_ph = 0, m_snap = 0, m_addr = 0, m_data = 0;
   bit m_dv = 0;

   always #(PER/2) clk = ~clk;

   bdr_order_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SEC_DEPTH(SD), .HOST_DEPTH(HD)) uut (
      .clk(clk), .rst_n(rst_n), .sec_wr_cnt(sec_wr_cnt), .host_wr_cnt(host_wr_cnt),
      .sec_wr_retire(sec_wr_retire), .sec_req_valid(sec_req_valid), .sec_req_write(sec_req_write),
      .sec_req_addr(sec_req_addr), .sec_accept(sec_accept), .sec_retry(sec_retry),
      .sec_rd_data(sec_rd_data), .sec_rd_data_valid(sec_rd_data_valid),
      .host_req_valid(host_req_valid), .host_req_write(host_req_write),
      .host_req_postable(host_req_postable), .host_req_cfg(host_req_cfg),
      .host_accept(host_accept), .host_rearb(host_rearb), .dn_rd_launch(dn_rd_launch),
      .dn_rd_addr(dn_rd_addr), .dn_rd_ret_valid(dn_rd_ret_valid), .dn_rd_ret_data(dn_rd_ret_data));

   task automatic clear_in();
      sec_wr_retire = 0; sec_req_valid = 0; sec_req_write = 0; sec_req_addr = '0;
      host_req_valid = 0; host_req_write = 0; host_req_postable = 0; host_req_cfg = 0;
      dn_rd_ret_valid = 0; dn_rd_ret_data = '0;
   endtask

   task automatic step(string tag);
      bit e_sacc, e_sret, e_dv, e_hacc, e_hrb, e_l, ok, deliver;
      int cs, ch;
      cs = int'(sec_wr_cnt); ch = int'(host_wr_cnt);
      deliver = sec_req_valid && !sec_req_write && m_ph == 2 && m_dv && int'(sec_req_addr) == m_addr;
      ok = sec_req_write ? (cs < SD) : deliver;
      e_sacc = sec_req_valid && ok; e_sret = sec_req_valid && !ok; e_dv = deliver;
      if (host_req_cfg) ok = host_req_write ? (cs == 0 && ch == 0 && m_ph == 0) : 1'b1;
      else if (host_req_write && host_req_postable) ok = ch < HD;
      else if (host_req_write) ok = !sec_req_valid;
      else ok = !sec_req_valid && cs == 0 && ch == 0;
      e_hacc = host_req_valid && ok; e_hrb = host_req_valid && !ok;
      e_l = (m_ph == 1) && (m_snap == 0);
      @(negedge clk);
      n_run++;
      if ({sec_accept, sec_retry, sec_rd_data_valid, host_accept, host_rearb, dn_rd_launch} !==
          {e_sacc, e_sret, e_dv, e_hacc, e_hrb, e_l} ||
          (e_dv && int'(sec_rd_data) != m_data) || (e_l && int'(dn_rd_addr) != m_addr)) begin
         n_fail++;
         $display("FAIL %s: got acc/ret/dv/hacc/hrb/l=%b%b%b%b%b%b data=%h addr=%h exp=%b%b%b%b%b%b data=%h addr=%h",
            tag, sec_accept, sec_retry, sec_rd_data_valid, host_accept, host_rearb, dn_rd_launch,
            sec_rd_data, dn_rd_addr, e_sacc, e_sret, e_dv, e_hacc, e_hrb, e_l, m_data, m_addr);
      end
      // model update at the coming edge
      if (m_ph == 0) begin
         if (sec_req_valid && !sec_req_write) begin
            m_ph = 1; m_addr = int'(sec_req_addr); m_snap = cs - int'(sec_wr_retire);
         end
      end else if (m_ph == 1) begin
         if (m_snap == 0) begin m_ph = 2; m_dv = 0; end
         else if (sec_wr_retire) m_snap--;
      end else begin
         if (deliver) begin m_ph = 0; m_dv = 0; end
         else if (dn_rd_ret_valid && !m_dv) begin m_dv = 1; m_data = int'(dn_rd_ret_data); end
      end
      @(posedge clk); #1;
      clear_in();
   endtask

   task automatic sec_rd(logic [AW-1:0] a);
      sec_req_valid = 1; sec_req_write = 0; sec_req_addr = a;
   endtask

   initial begin
      #(PER*200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1; #1;
      // R1: reset state, idle
      step("R1 idle after reset"); step("R1 idle after reset");
      // R2: secondary writes
      sec_wr_cnt = 3; sec_req_valid = 1; sec_req_write = 1; step("R2 write below full");
      sec_wr_cnt = 4; sec_req_valid = 1; sec_req_write = 1; step("R2 write at full");
      sec_wr_cnt = 0;
      // R7: postable host writes independent of secondary activity
      host_wr_cnt = 3; host_req_valid = 1; host_req_write = 1; host_req_postable = 1;
      sec_req_valid = 1; sec_req_write = 1; step("R7 postable write, sec busy");
      host_wr_cnt = 4; host_req_valid = 1; host_req_write = 1; host_req_postable = 1; step("R7 postable write full");
      // R8 / R9: host reads and non-postable writes
      host_wr_cnt = 1; host_req_valid = 1; step("R8 host read, host buffer busy");
      host_wr_cnt = 0; sec_wr_cnt = 2; host_req_valid = 1; step("R8 host read, sec buffer busy");
      sec_wr_cnt = 0; host_req_valid = 1; step("R8 host read, both empty");
      host_req_valid = 1; sec_req_valid = 1; sec_req_write = 1; step("R9 host read vs sec write");
      host_req_valid = 1; host_req_write = 1; sec_req_valid = 1; sec_req_write = 1; step("R9 non-postable write vs sec");
      host_req_valid = 1; host_req_write = 1; step("R9 non-postable write alone");
      // R10: config accesses
      host_req_valid = 1; host_req_write = 1; host_req_cfg = 1; step("R10 cfg write quiet");
      host_wr_cnt = 1; host_req_valid = 1; host_req_write = 1; host_req_cfg = 1; step("R10 cfg write host busy");
      host_req_valid = 1; host_req_cfg = 1; step("R10 cfg read");
      host_wr_cnt = 0;
      // R3/R4: delayed read with two pending writes
      sec_wr_cnt = 2; sec_rd(16'h1230); step("R3 first read retried");
      sec_rd(16'h1230); step("R3 read retried in request phase");
      sec_wr_cnt = 3; sec_req_valid = 1; sec_req_write = 1; step("R4 new write during drain");
      host_req_valid = 1; host_req_write = 1; host_req_cfg = 1; step("R10 cfg write during delayed read");
      sec_wr_retire = 1; sec_wr_cnt = 3; step("R4 first retire");
      sec_wr_cnt = 2; step("R4 waiting after one retire");
      sec_wr_retire = 1; step("R4 second retire");
      sec_wr_cnt = 1; step("R5 launch after drain");
      // R6: completion phase
      sec_wr_cnt = 1; sec_rd(16'h1230); step("R6 match before data retried");
      dn_rd_ret_valid = 1; dn_rd_ret_data = 16'hBEEF; sec_rd(16'h1230); step("R6 return cycle retried");
      dn_rd_ret_valid = 1; dn_rd_ret_data = 16'h0BAD; sec_rd(16'h4440); step("R3 mismatch retried");
      sec_rd(16'h1230); step("R6 matching read delivered");
      step("R1 idle after delivery");
      // zero-pending delayed read, retire in start cycle
      sec_wr_cnt = 1; sec_wr_retire = 1; sec_rd(16'h0008); step("R4 start with retire");
      sec_wr_cnt = 0; step("R5 immediate launch");
      sec_rd(16'h0008); step("R6 early retry");
      dn_rd_ret_valid = 1; dn_rd_ret_data = 16'h5A5A; step("R6 data return");
      sec_rd(16'h0008); host_req_valid = 1; step("R6 deliver with host read R9");
      step("R1 idle at end");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule